// File: doc/BRIEF.md
# Registered Bus Driver with Latch Bypass

This block drives a parameterised data bus (20 bits by default) toward a shared tri-state bus. Each data bit reaches the output by one of two routes. In the pass-through route the output follows the data input. In the held route the output shows a stored word, and that word is reloaded on every rising edge of a separate capture strobe. A single active-low drive enable, a single active-low bypass select and a single capture strobe control every bit.

All control and data inputs are sampled by a free-running system clock. The capture strobe is treated as data: its rising edge is found by comparing two consecutive samples. Inside the block the tri-state output exists as a data word plus a drive flag. The high-impedance value is formed only at the top-level pad port.

When the block leaves pass-through, the held word depends on the strobe level at the moment pass-through began. If the strobe was high, the storage followed the passed data and keeps the last word passed. If the strobe was low, the storage kept the word from the last strobe capture.

Top module: `regbus_driver`

## Requirements
- R1: When `drv_n` is sampled high, `y_oe` is low after that system clock edge, whatever the other inputs are. `y_pad` is then high impedance.
- R2: When `drv_n` and `byp_n` are both sampled low, `y_oe` is high after that edge and `y_data` equals the `din` sampled at the same edge.
- R3: With `byp_n` high, a strobe rise is the first edge at which `strobe` is sampled high after being sampled low. The `din` sampled at that edge is stored, and it appears on `y_data` after the next edge.
- R4: With `byp_n` high, a strobe that stays high or stays low leaves `y_data` unchanged.
- R5: If `strobe` was sampled high at the edge where `byp_n` was first sampled low, then after `byp_n` returns high `y_data` holds the last word passed through.
- R6: If `strobe` was sampled low at the edge where `byp_n` was first sampled low, then after `byp_n` returns high `y_data` holds the word from the last strobe rise.
- R7: A strobe rise while `byp_n` is low does not change the pass-through output and does not load the storage.
- R8: A synchronous active-high `rst` clears the storage to zero, disables the output and clears the strobe history to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| drv_n | input | 1 | Output drive enable, active low |
| byp_n | input | 1 | Pass-through select, active low |
| strobe | input | 1 | Capture strobe, rising edge loads storage |
| din | input | W | Data input word |
| y_data | output | W | Output word, valid while y_oe is high |
| y_oe | output | 1 | Output drive flag |
| y_pad | output | W | Resolved tri-state bus (z when not driven) |

## Verification
Directed sequences exercise each mode transition:
- A strobe rise with bypass off separates capture from hold.
- A steady strobe, high and then low, shows the output does not move.
- Two exits from pass-through separate the strobe-high entry from the strobe-low entry. In the strobe-low case, a strobe rise inside pass-through shows that the storage ignores it.

Random stimulus then runs for several thousand cycles. The bypass select changes rarely, the strobe toggles often and drive-disable bursts are short. This exposes a wrong word held on exit and a capture taken one sample too early or too late. Each value is compared with a bench model of the sampled behaviour.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    // registered control samples and their one-cycle history
    typedef struct packed {
        logic drv_n;
        logic byp_n;
        logic strobe;
        logic strobe_prev;
        logic byp_prev;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{drv_n: 1'b1, byp_n: 1'b1, strobe: 1'b0,
                                  strobe_prev: 1'b0, byp_prev: 1'b1};

endpackage

// File: rtl/regbus_sampler.sv
module regbus_sampler
    import regbus_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drv_n,
    input  logic         byp_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output ctl_t         ctl_q,
    output logic [W-1:0] din_q,
    output logic         strobe_rise,
    output logic         byp_fall
);

    typedef struct packed {
        ctl_t         ctl;
        logic [W-1:0] data;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d                 = smp_q;
        smp_d.ctl.drv_n       = drv_n;
        smp_d.ctl.byp_n       = byp_n;
        smp_d.ctl.strobe      = strobe;
        smp_d.ctl.strobe_prev = smp_q.ctl.strobe;
        smp_d.ctl.byp_prev    = smp_q.ctl.byp_n;
        smp_d.data            = din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q.ctl  <= CTL_IDLE;
            smp_q.data <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign ctl_q       = smp_q.ctl;
    assign din_q       = smp_q.data;
    assign strobe_rise = smp_q.ctl.strobe & ~smp_q.ctl.strobe_prev;
    assign byp_fall    = ~smp_q.ctl.byp_n & smp_q.ctl.byp_prev;

    // R8
    hist_reset_chk: assert property (@(posedge clk) rst |=> (!strobe_rise && !byp_fall))
        else $error("strobe or bypass history not cleared by reset");

endmodule

// File: rtl/regbus_store.sv
module regbus_store #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         byp_n_q,
    input  logic         strobe_q,
    input  logic         strobe_rise,
    input  logic         byp_fall,
    input  logic [W-1:0] din_q,
    output logic [W-1:0] hold_q
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         follow;
    } st_t;

    st_t  st_d, st_q;
    logic follow_now;

    always_comb begin
        st_d        = st_q;
        follow_now  = ~byp_n_q & (byp_fall ? strobe_q : st_q.follow);
        st_d.follow = byp_fall ? strobe_q : st_q.follow;
        if (byp_n_q && strobe_rise) begin
            st_d.word = din_q;
        end else if (follow_now) begin
            st_d.word = din_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_q = st_q.word;

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (byp_n_q && strobe_rise) |=> (hold_q == $past(din_q)))
        else $error("strobe rise did not load storage");

    // R4
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (byp_n_q && !strobe_rise) |=> $stable(hold_q))
        else $error("storage moved without a strobe rise");

    // R7
    bypass_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!byp_n_q && !byp_fall && !st_q.follow) |=> $stable(hold_q))
        else $error("storage loaded during strobe-low pass-through");

endmodule

// File: rtl/regbus_outmux.sv
module regbus_outmux #(
    parameter int W = 20
) (
    input  logic         drv_n_q,
    input  logic         byp_n_q,
    input  logic [W-1:0] din_q,
    input  logic [W-1:0] hold_q,
    output logic [W-1:0] y_data,
    output logic         y_oe
);

    always_comb begin
        y_oe   = ~drv_n_q;
        y_data = byp_n_q ? hold_q : din_q;
    end

endmodule

// File: rtl/regbus_driver.sv
module regbus_driver
    import regbus_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drv_n,
    input  logic         byp_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] y_data,
    output logic         y_oe,
    output logic [W-1:0] y_pad
);

    ctl_t         ctl_q;
    logic [W-1:0] din_q;
    logic [W-1:0] hold_q;
    logic         strobe_rise;
    logic         byp_fall;

    regbus_sampler #(.W(W)) u_sampler (
        .clk         (clk),
        .rst         (rst),
        .drv_n       (drv_n),
        .byp_n       (byp_n),
        .strobe      (strobe),
        .din         (din),
        .ctl_q       (ctl_q),
        .din_q       (din_q),
        .strobe_rise (strobe_rise),
        .byp_fall    (byp_fall)
    );

    regbus_store #(.W(W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .byp_n_q     (ctl_q.byp_n),
        .strobe_q    (ctl_q.strobe),
        .strobe_rise (strobe_rise),
        .byp_fall    (byp_fall),
        .din_q       (din_q),
        .hold_q      (hold_q)
    );

    regbus_outmux #(.W(W)) u_outmux (
        .drv_n_q (ctl_q.drv_n),
        .byp_n_q (ctl_q.byp_n),
        .din_q   (din_q),
        .hold_q  (hold_q),
        .y_data  (y_data),
        .y_oe    (y_oe)
    );

    assign y_pad = y_oe ? y_data : {W{1'bz}};

    // R1
    drive_off_chk: assert property (@(posedge clk) disable iff (rst)
        drv_n |=> !y_oe)
        else $error("output driven while disabled");

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (!drv_n && !byp_n) |=> (y_oe && y_data == $past(din)))
        else $error("pass-through word mismatch");

    // R8
    reset_state_chk: assert property (@(posedge clk) rst |=> (!y_oe && hold_q == '0))
        else $error("reset did not clear output state");

endmodule

// File: tb/regbus_driver_test.sv
`timescale 1ns/1ps
module regbus_driver_test;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         drv_n = 1'b1, byp_n = 1'b1, strobe = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] y_data, y_pad;
    logic         y_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the sampled behaviour
    logic         p1_le, p2_le, p1_cp, p2_cp, m_follow;
    logic [W-1:0] p1_d, m_hold;
    logic         e_oe;
    logic [W-1:0] e_data;

    regbus_driver #(.W(W)) uut (
        .clk(clk), .rst(rst), .drv_n(drv_n), .byp_n(byp_n), .strobe(strobe),
        .din(din), .y_data(y_data), .y_oe(y_oe), .y_pad(y_pad)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] exp_word(input logic le, input logic [W-1:0] d,
                                              input logic [W-1:0] h);
        return le ? h : d;
    endfunction

    task automatic model_init();
        p1_le = 1'b1; p2_le = 1'b1; p1_cp = 1'b0; p2_cp = 1'b0;
        m_follow = 1'b0; p1_d = '0; m_hold = '0; e_oe = 1'b0; e_data = '0;
    endtask

    task automatic model_edge(input logic oe_n_s, input logic le_s, input logic cp_s,
                              input logic [W-1:0] d_s);
        logic rise, fall, fol;
        rise = p1_cp & ~p2_cp;
        fall = ~p1_le & p2_le;
        fol  = fall ? p1_cp : m_follow;
        if (p1_le && rise) m_hold = p1_d;
        else if (!p1_le && fol) m_hold = p1_d;
        m_follow = fol;
        p2_le = p1_le; p2_cp = p1_cp;
        p1_le = le_s; p1_cp = cp_s; p1_d = d_s;
        e_oe   = ~oe_n_s;
        e_data = exp_word(le_s, d_s, m_hold);
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s y_oe actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [W-1:0] act,
                              input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s y_data actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic tick(input logic oe_n_v, input logic le_v, input logic cp_v,
                        input logic [W-1:0] d_v);
        string tag;
        drv_n = oe_n_v; byp_n = le_v; strobe = cp_v; din = d_v;
        @(posedge clk);
        model_edge(oe_n_v, le_v, cp_v, d_v);
        @(negedge clk);
        tag = oe_n_v ? "R1" : (!le_v ? "R2" : "R3");
        check_bit(tag, y_oe, e_oe);
        if (e_oe) check_word(tag, y_data, e_data);
    endtask

    initial begin
        void'($urandom(32'h5EED_0123));
        model_init();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        check_bit("R8", y_oe, 1'b0);
        tick(1'b0, 1'b1, 1'b0, 20'hAAAAA);
        check_word("R8", y_data, 20'h00000);

        // R3 capture on strobe rise
        tick(1'b0, 1'b1, 1'b1, 20'h11111);
        tick(1'b0, 1'b1, 1'b1, 20'h22222);
        check_word("R3", y_data, 20'h11111);
        // R4 steady strobe low, then steady high
        tick(1'b0, 1'b1, 1'b0, 20'h33333);
        tick(1'b0, 1'b1, 1'b0, 20'h34343);
        check_word("R4", y_data, 20'h11111);
        tick(1'b0, 1'b1, 1'b1, 20'h44444);
        tick(1'b0, 1'b1, 1'b1, 20'h45454);
        tick(1'b0, 1'b1, 1'b1, 20'h46464);
        check_word("R4", y_data, 20'h44444);

        // R5 enter pass-through with strobe high
        tick(1'b0, 1'b0, 1'b1, 20'h55555);
        check_word("R2", y_data, 20'h55555);
        tick(1'b0, 1'b0, 1'b1, 20'h66666);
        tick(1'b0, 1'b1, 1'b1, 20'h77777);
        check_word("R5", y_data, 20'h66666);
        tick(1'b0, 1'b1, 1'b1, 20'h78787);
        check_word("R5", y_data, 20'h66666);

        // R6 and R7 enter pass-through with strobe low
        tick(1'b0, 1'b1, 1'b0, 20'h0ABCD);
        tick(1'b0, 1'b1, 1'b1, 20'h0BEEF);
        tick(1'b0, 1'b1, 1'b0, 20'h01234);
        check_word("R3", y_data, 20'h0BEEF);
        tick(1'b0, 1'b0, 1'b0, 20'h0F00D);
        tick(1'b0, 1'b0, 1'b1, 20'h0CAFE);
        check_word("R7", y_data, 20'h0CAFE);
        tick(1'b0, 1'b0, 1'b1, 20'h0D00D);
        check_word("R7", y_data, 20'h0D00D);
        tick(1'b0, 1'b1, 1'b1, 20'h09999);
        check_word("R6", y_data, 20'h0BEEF);

        // R1 drive disable in every mode
        tick(1'b1, 1'b0, 1'b0, 20'h12345);
        check_bit("R1", y_oe, 1'b0);
        tick(1'b1, 1'b1, 1'b1, 20'h54321);
        check_bit("R1", y_oe, 1'b0);
        tick(1'b0, 1'b1, 1'b1, 20'h54321);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic oe_r, le_r, cp_r;
            oe_r = ($urandom % 16) == 0;
            le_r = (($urandom % 12) == 0) ? ~byp_n : byp_n;
            cp_r = (($urandom % 3) == 0) ? ~strobe : strobe;
            tick(oe_r, le_r, cp_r, W'($urandom));
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule